// File: doc/BRIEF.md
# Byte Field Insert, Extract and Mask Unit

This unit is one stage of a 64-bit integer pipeline that handles byte-granular field operations. Given a data operand and a second operand that supplies a byte offset or a byte-select pattern, it can do four things:

- place a narrow field at a byte position;
- pull a field out from a byte position;
- clear a field at a byte position;
- clear whole bytes chosen by an 8-bit pattern.

Decode drives the operation class, the low/high choice and the field size. The unit returns the 64-bit answer from a register one cycle after the request.

The second operand comes either from a 64-bit register value or from an 8-bit literal that is zero-extended. The byte offset `k` is the low three bits of that operand, and the bit shift is `s = 8*k`. Each low variant works toward higher bit positions from the offset. Each high variant works with the part of a field that would spill past bit 63. Because of that, an offset of zero needs its own handling in every high variant.

Top module: `bytefield_unit`

## Requirements
- R1: The effective second operand is `opb` when `use_lit`=0, and `{56'b0, lit}` when `use_lit`=1. The shift `s` is its bits [2:0] times 8, which gives 0, 8, …, 56.
- R2: `size_sel` picks the field mask M: 0 gives 0xFF, 1 gives 0xFFFF, 2 gives 0xFFFF_FFFF, and 3 gives all 64 ones.
- R3: `op_class`=0 (insert) with `hi_sel`=0 gives `(opa & M) << s`.
- R4: `op_class`=0 with `hi_sel`=1 gives `(opa & M) >> (64-s)`. The result is zero when s=0.
- R5: `op_class`=1 (extract) with `hi_sel`=0 gives `(opa >> s) & M`.
- R6: `op_class`=1 with `hi_sel`=1 gives `(opa << (64-s)) & M`. When s=0 it gives `opa & M`.
- R7: `op_class`=2 (mask) gives `opa & ~C`. With `hi_sel`=0, C is `M << s`. With `hi_sel`=1, C is `M >> (64-s)`, and C is zero when s=0.
- R8: `op_class`=3 (zap) clears byte i of `opa` (bits 8i+7..8i) for each set bit i of the low 8 bits of the effective second operand. `op_class`=4 (zap-not) clears byte i for each clear bit i. `hi_sel` and `size_sel` have no effect on either.
- R9: `op_class` codes 5 to 7 return `opa` unchanged.
- R10: When `in_valid` is sampled high at a rising edge, `result` takes the answer and `out_valid` is 1 after that edge. When `in_valid` is sampled low, `out_valid` is 0 after the edge and `result` keeps its value.
- R11: A synchronous `rst` sampled high makes `result` zero and `out_valid` 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_class | input | 3 | 0 insert, 1 extract, 2 mask, 3 zap, 4 zap-not |
| hi_sel | input | 1 | 0 low variant, 1 high variant |
| size_sel | input | 2 | Field size: byte, 16, 32, 64 bits |
| use_lit | input | 1 | Select the literal as second operand |
| opa | input | 64 | Data operand |
| opb | input | 64 | Register second operand |
| lit | input | 8 | Literal second operand |
| out_valid | output | 1 | Result valid, one cycle after request |
| result | output | 64 | Registered answer |

## Verification
An offset or size decoded wrongly shows up at `result` in the cycle right after the request, as bytes in the wrong place or a field of the wrong width. The offset-zero cases of the high variants are driven directly, because a shift by a full 64 bits is the most likely silent error. A handshake fault shows up as `out_valid` that fails to rise one cycle after `in_valid`, or as `result` moving while the unit is idle. Both are visible one cycle after the request, or on the first idle cycle.

// File: rtl/bytefield_pkg.sv
package bytefield_pkg;
  localparam int unsigned BF_W     = 64;
  localparam int unsigned BF_BYTES = BF_W / 8;
  localparam int unsigned OFF_W    = $clog2(BF_BYTES);
  localparam int unsigned SH_W     = OFF_W + 4;

  typedef enum logic [2:0] {
    OP_INS  = 3'd0,
    OP_EXT  = 3'd1,
    OP_MSK  = 3'd2,
    OP_ZAP  = 3'd3,
    OP_ZAPN = 3'd4
  } bf_op_e;

  typedef logic [BF_W-1:0] word_t;

  function automatic word_t width_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return word_t'(8'hFF);
      2'd1:    return word_t'(16'hFFFF);
      2'd2:    return word_t'(32'hFFFF_FFFF);
      default: return '1;
    endcase
  endfunction

  // Right shift by the complement of sh; an offset of zero yields nothing.
  function automatic word_t spill_right(input word_t v, input logic [SH_W-1:0] sh);
    if (sh == '0) return '0;
    return v >> (int'(BF_W) - int'(sh));
  endfunction

  // Left shift by the complement of sh; an offset of zero keeps v.
  function automatic word_t spill_left(input word_t v, input logic [SH_W-1:0] sh);
    if (sh == '0) return v;
    return v << (int'(BF_W) - int'(sh));
  endfunction
endpackage

// File: rtl/bf_operand.sv
module bf_operand
  import bytefield_pkg::*;
(
  input  logic [BF_W-1:0]     opb,
  input  logic [7:0]          lit,
  input  logic                use_lit,
  output logic [SH_W-1:0]     shift_amt,
  output logic [BF_BYTES-1:0] byte_sel
);
  logic [BF_W-1:0] bsrc;
  logic            unused_hi;

  assign bsrc      = use_lit ? BF_W'(lit) : opb;
  assign shift_amt = {bsrc[OFF_W-1:0], 3'b000};
  assign byte_sel  = bsrc[BF_BYTES-1:0];
  assign unused_hi = ^bsrc[BF_W-1:BF_BYTES];
endmodule

// File: rtl/bf_core.sv
module bf_core
  import bytefield_pkg::*;
(
  input  logic [BF_W-1:0]     opa,
  input  logic [2:0]          op,
  input  logic                hi,
  input  logic [1:0]          sz,
  input  logic [SH_W-1:0]     shift_amt,
  input  logic [BF_BYTES-1:0] byte_sel,
  output logic [BF_W-1:0]     width_m,
  output logic [BF_W-1:0]     comb_result
);
  logic [BF_BYTES-1:0] zsel;
  logic [BF_W-1:0]     zap_keep;
  logic [BF_W-1:0]     field;
  logic [BF_W-1:0]     clr_m;

  assign width_m = width_mask(sz);
  assign field   = opa & width_m;
  assign clr_m   = hi ? spill_right(width_m, shift_amt) : (width_m << shift_amt);
  assign zsel    = (op == OP_ZAPN) ? ~byte_sel : byte_sel;

  for (genvar i = 0; i < BF_BYTES; i++) begin : g_keep
    assign zap_keep[8*i +: 8] = {8{~zsel[i]}};
  end

  always_comb begin
    case (bf_op_e'(op))
      OP_INS:  comb_result = hi ? spill_right(field, shift_amt) : (field << shift_amt);
      OP_EXT:  comb_result = (hi ? spill_left(opa, shift_amt) : (opa >> shift_amt)) & width_m;
      OP_MSK:  comb_result = opa & ~clr_m;
      OP_ZAP,
      OP_ZAPN: comb_result = opa & zap_keep;
      default: comb_result = opa;
    endcase
  end
endmodule

// File: rtl/bytefield_unit.sv
module bytefield_unit
  import bytefield_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [2:0]      op_class,
  input  logic            hi_sel,
  input  logic [1:0]      size_sel,
  input  logic            use_lit,
  input  logic [BF_W-1:0] opa,
  input  logic [BF_W-1:0] opb,
  input  logic [7:0]      lit,
  output logic            out_valid,
  output logic [BF_W-1:0] result
);
  logic [SH_W-1:0]     shift_amt;
  logic [BF_BYTES-1:0] byte_sel;
  logic [BF_W-1:0]     width_m;
  logic [BF_W-1:0]     comb_result;

  bf_operand u_opnd (
    .opb       (opb),
    .lit       (lit),
    .use_lit   (use_lit),
    .shift_amt (shift_amt),
    .byte_sel  (byte_sel)
  );

  bf_core u_core (
    .opa         (opa),
    .op          (op_class),
    .hi          (hi_sel),
    .sz          (size_sel),
    .shift_amt   (shift_amt),
    .byte_sel    (byte_sel),
    .width_m     (width_m),
    .comb_result (comb_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= comb_result;
    end
  end
endmodule

// File: rtl/bytefield_unit_chk.sv
module bytefield_unit_chk
  import bytefield_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [2:0]      op_class,
  input logic            hi_sel,
  input logic [1:0]      size_sel,
  input logic [BF_W-1:0] opa,
  input logic [SH_W-1:0] shift_amt,
  input logic [BF_W-1:0] width_m,
  input logic            out_valid,
  input logic [BF_W-1:0] result
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && $stable(result))); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && result == '0)); // R11
  AST_INS_HI_ZERO: assert property (@(posedge clk) disable iff (rst) (in_valid && op_class == OP_INS && hi_sel && shift_amt == '0) |=> result == '0); // R4
  AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (rst) (in_valid && (op_class == OP_MSK || op_class == OP_ZAP || op_class == OP_ZAPN)) |=> (result & ~$past(opa)) == '0); // R7
  AST_EXT_WIDTH: assert property (@(posedge clk) disable iff (rst) (in_valid && op_class == OP_EXT) |=> (result & ~$past(width_m)) == '0); // R5
  AST_BYTE_INS_BITS: assert property (@(posedge clk) disable iff (rst) (in_valid && op_class == OP_INS && size_sel == 2'd0) |=> $countones(result) <= 8); // R3
endmodule

bind bytefield_unit bytefield_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_class  (op_class),
  .hi_sel    (hi_sel),
  .size_sel  (size_sel),
  .opa       (opa),
  .shift_amt (shift_amt),
  .width_m   (width_m),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/bytefield_unit_test.sv
`timescale 1ns/1ps
module bytefield_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  op_class;
  logic        hi_sel;
  logic [1:0]  size_sel;
  logic        use_lit;
  logic [63:0] opa, opb;
  logic [7:0]  lit;
  logic        out_valid;
  logic [63:0] result;

  int n_run = 0;
  int n_fail = 0;
  logic [63:0] last_res;

  always #5 clk = ~clk;

  bytefield_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_class(op_class),
    .hi_sel(hi_sel), .size_sel(size_sel), .use_lit(use_lit),
    .opa(opa), .opb(opb), .lit(lit), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] m_of(input logic [1:0] sz);
    logic [63:0] m = '0;
    for (int i = 0; i < 8 * (1 << sz); i++) m[i] = 1'b1;
    return m;
  endfunction

  // Model written with 128-bit windows instead of complemented shifts.
  function automatic logic [63:0] model(input logic [2:0] op, input logic hi,
      input logic [1:0] sz, input logic [63:0] a, input logic [63:0] b);
    int          s = int'(b[2:0]) * 8;
    logic [63:0] m = m_of(sz);
    logic [127:0] w;
    logic [63:0] r = a;
    case (op)
      3'd0: begin
        w = {64'b0, a & m} << s;
        r = hi ? w[127:64] : w[63:0];
      end
      3'd1: begin
        if (!hi) r = (a >> s) & m;
        else if (s == 0) r = a & m;
        else begin w = {a, 64'b0} >> s; r = w[63:0] & m; end
      end
      3'd2: begin
        w = {64'b0, m} << s;
        r = a & ~(hi ? w[127:64] : w[63:0]);
      end
      3'd3, 3'd4: begin
        for (int i = 0; i < 8; i++)
          if (b[i] ^ (op == 3'd4)) r[8*i +: 8] = 8'h00;
      end
      default: r = a;
    endcase
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_op(input string req, input logic [2:0] op, input logic hi,
      input logic [1:0] sz, input logic ul, input logic [63:0] a,
      input logic [63:0] b, input logic [7:0] l);
    logic [63:0] exp;
    @(negedge clk);
    in_valid = 1'b1; op_class = op; hi_sel = hi; size_sel = sz;
    use_lit = ul; opa = a; opb = b; lit = l;
    exp = model(op, hi, sz, a, ul ? {56'b0, l} : b);
    @(posedge clk); #1;
    chk({req, " result"}, result, exp);
    chk({req, " out_valid"}, {63'b0, out_valid}, 64'd1);
    last_res = result;
  endtask

  task automatic idle_chk();
    @(negedge clk);
    in_valid = 1'b0; opa = ~opa;
    @(posedge clk); #1;
    chk("R10 idle out_valid", {63'b0, out_valid}, 64'd0);
    chk("R10 idle hold", result, last_res);
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] pat = 64'h0123_4567_89AB_CDEF;
    void'($urandom(32'd2024));
    rst = 1'b1; in_valid = 1'b0; op_class = '0; hi_sel = 1'b0; size_sel = '0;
    use_lit = 1'b0; opa = '0; opb = '0; lit = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset out_valid", {63'b0, out_valid}, 64'd0);
    chk("R11 reset result", result, 64'd0);
    @(negedge clk); rst = 1'b0;

    do_op("R3 ins lo byte k3", 3'd0, 1'b0, 2'd0, 1'b0, pat, 64'd3, 8'd0);
    do_op("R3 ins lo quad k7", 3'd0, 1'b0, 2'd3, 1'b0, pat, 64'd7, 8'd0);
    do_op("R4 ins hi k0", 3'd0, 1'b1, 2'd3, 1'b0, pat, 64'd8, 8'd0);
    do_op("R4 ins hi long k6", 3'd0, 1'b1, 2'd2, 1'b0, pat, 64'd6, 8'd0);
    do_op("R5 ext lo word k5", 3'd1, 1'b0, 2'd1, 1'b0, pat, 64'd5, 8'd0);
    do_op("R6 ext hi k0", 3'd1, 1'b1, 2'd2, 1'b0, pat, 64'd0, 8'd0);
    do_op("R6 ext hi quad k1", 3'd1, 1'b1, 2'd3, 1'b0, pat, 64'd1, 8'd0);
    do_op("R7 msk lo word k7", 3'd2, 1'b0, 2'd1, 1'b0, pat, 64'd7, 8'd0);
    do_op("R7 msk hi k0", 3'd2, 1'b1, 2'd3, 1'b0, pat, 64'd0, 8'd0);
    do_op("R7 msk hi long k6", 3'd2, 1'b1, 2'd2, 1'b0, pat, 64'd6, 8'd0);
    do_op("R8 zap", 3'd3, 1'b1, 2'd1, 1'b0, pat, 64'h0000_0000_0000_00A5, 8'd0);
    do_op("R8 zapnot", 3'd4, 1'b0, 2'd0, 1'b0, pat, 64'hFFFF_FFFF_FFFF_FF0F, 8'd0);
    do_op("R1 literal offset", 3'd0, 1'b0, 2'd0, 1'b1, pat, 64'd0, 8'hF2);
    do_op("R1 literal zap", 3'd3, 1'b0, 2'd0, 1'b1, pat, 64'hFF, 8'h81);
    do_op("R2 size word ext", 3'd1, 1'b0, 2'd1, 1'b0, '1, 64'd0, 8'd0);
    do_op("R9 unused code", 3'd6, 1'b1, 2'd2, 1'b0, pat, 64'd4, 8'd0);
    idle_chk();

    for (int n = 0; n < 600; n++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      do_op("R1-R9 random", 3'($urandom_range(0, 7)), 1'($urandom),
            2'($urandom), 1'($urandom), a, b, 8'($urandom));
      if ((n % 50) == 0) idle_chk();
    end

    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); #1;
    chk("R11 reset over request", result, 64'd0);
    chk("R11 reset valid", {63'b0, out_valid}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule